// File: doc/BRIEF.md
# Delayed Even-Ones Toggle Output

This block watches a serial bit stream, one bit per clock, and keeps a single output level. The level starts low and inverts once for every second `1` seen on the input: the second, fourth, sixth `1`, and so on. The inversion becomes visible in the clock period after the one that carried the triggering `1`. `0` bits and odd-numbered `1` bits leave the level alone.

The machine is a Moore machine with four states. Each state combines the parity of the `1`s counted so far with the present output level. The output is a state register bit, so it depends only on state and stays glitch-free. A change of the input within a clock period is never seen at the output before the next rising edge. An asynchronous active-low reset sets even parity and a low output.

Top module: `even_ones_toggle`

## Requirements
- R1: While `rst_ni` is low, and in the first period after it rises, `z_o` is 0 and the count of `1`s is even.
- R2: A `1` sampled while the count is even makes the count odd and leaves `z_o` unchanged in the next period.
- R3: A `1` sampled while the count is odd makes the count even, and `z_o` is inverted in the next clock period.
- R4: A `0` sampled at a rising edge changes neither `z_o` nor the count.
- R5: Changes of `x_i` between rising edges do not change `z_o` before the next rising edge.
- R6: After reset, the input stream 0,0,1,1,0,0,0,1,0,1,0,1,1,1,0 (first bit first) gives `z_o` values 0,0,0,0,1,1,1,1,1,1,0,0,0,1,1, one per period, in the same periods as the input bits.
- R7: A reset in the middle of a stream clears a pending odd `1`. After reset the first `1` does not invert `z_o` and the second one does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the input is sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial input bit |
| z_o | output | 1 | Output level, driven straight from a state register bit |

## Verification
A parity bit in the wrong state does not show at the ports at once. It shows as an inversion of `z_o` one `1` too early or one `1` too late, so the fault appears one period after the next `1` on the input. A wrong output bit shows at `z_o` in the very next period. The bench uses runs of `1`s of both odd and even length, long runs of `0`s, a reset with an odd `1` pending, and input changes between edges. Together these expose both kinds of fault within a few cycles.

// File: rtl/even_ones_toggle_pkg.sv
`timescale 1ns/1ps
package even_ones_toggle_pkg;
  // bit 1: output level, bit 0: ones parity (1 = odd)
  typedef enum logic [1:0] {
    ST_EVEN_LO = 2'b00,
    ST_ODD_LO  = 2'b01,
    ST_EVEN_HI = 2'b10,
    ST_ODD_HI  = 2'b11
  } eot_state_e;

  localparam int unsigned OUT_BIT = 1;
  localparam int unsigned PAR_BIT = 0;
endpackage

// File: rtl/eot_next_state.sv
`timescale 1ns/1ps
module eot_next_state
  import even_ones_toggle_pkg::*;
(
  input  eot_state_e state_i,
  input  logic       x_i,
  output eot_state_e state_o
);
  always_comb begin
    state_o = state_i;
    if (x_i) begin
      unique case (state_i)
        ST_EVEN_LO: state_o = ST_ODD_LO;
        ST_ODD_LO:  state_o = ST_EVEN_HI;  // even 1: invert output
        ST_EVEN_HI: state_o = ST_ODD_HI;
        ST_ODD_HI:  state_o = ST_EVEN_LO;  // even 1: invert output
        default:    state_o = ST_EVEN_LO;
      endcase
    end
  end
endmodule

// File: rtl/eot_state_reg.sv
`timescale 1ns/1ps
module eot_state_reg
  import even_ones_toggle_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  eot_state_e d_i,
  output eot_state_e q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= ST_EVEN_LO;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/even_ones_toggle.sv
`timescale 1ns/1ps
module even_ones_toggle
  import even_ones_toggle_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_o
);
  eot_state_e state_q;
  eot_state_e state_d;

  eot_next_state i_next (
    .state_i(state_q),
    .x_i    (x_i),
    .state_o(state_d)
  );

  eot_state_reg i_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (state_d),
    .q_o   (state_q)
  );

  assign z_o = state_q[OUT_BIT];
endmodule

// File: rtl/even_ones_toggle_chk.sv
`timescale 1ns/1ps
module even_ones_toggle_chk
  import even_ones_toggle_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       x_i,
  input logic       z_i,
  input eot_state_e state_i
);
  logic par;
  assign par = state_i[PAR_BIT];

  assert_reset_low_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!z_i && !par));

  assert_odd_one_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i && !par) |=> (par && z_i == $past(z_i)));

  assert_even_one_toggles_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_i && par) |=> (!par && z_i != $past(z_i)));

  assert_zero_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_i |=> ($stable(z_i) && $stable(par)));
endmodule

bind even_ones_toggle even_ones_toggle_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .x_i    (x_i),
  .z_i    (z_o),
  .state_i(state_q)
);

// File: tb/test_even_ones_toggle.sv
`timescale 1ns/1ps
module test_even_ones_toggle;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x = 1'b0;
  logic z;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model
  bit exp_z = 1'b0;
  bit exp_par = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  even_ones_toggle i_even_ones_toggle (
    .clk_i (clk),
    .rst_ni(rst_n),
    .x_i   (x),
    .z_o   (z)
  );

  task automatic check(input string req, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: z actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive one bit, check z of this period, consume at next edge
  task automatic step(input bit xv, input string req);
    @(negedge clk);
    x = xv;
    #1 check(req, z, exp_z);
    if (xv) begin
      if (exp_par) exp_z = ~exp_z;
      exp_par = ~exp_par;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    x = 1'b0;
    #1 check("R1 during reset", z, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_z = 1'b0;
    exp_par = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    step(1'b0, "R1 first period after reset");
    step(1'b0, "R4 idle after reset");
  endtask

  task automatic t_odd_ones();
    do_reset();
    step(1'b1, "R2 before first 1");
    step(1'b0, "R2 after first 1 no change");
    step(1'b0, "R4 zero holds odd parity");
    step(1'b1, "R3 before second 1");
    step(1'b0, "R3 toggled after second 1");
  endtask

  task automatic t_even_toggle();
    do_reset();
    for (int i = 0; i < 9; i++) step(1'b1, "R3 run of ones");
    step(1'b0, "R3 after odd run");
    step(1'b1, "R3 completes pair");
    step(1'b0, "R3 after pair");
  endtask

  task automatic t_zeros_hold();
    do_reset();
    step(1'b1, "R4 setup");
    step(1'b1, "R4 setup");
    for (int i = 0; i < 12; i++) step(1'b0, "R4 long zero run");
    step(1'b1, "R4 parity kept even");
    step(1'b0, "R4 no toggle on first 1");
  endtask

  task automatic t_moore();
    do_reset();
    step(1'b1, "R5 setup odd parity");
    @(negedge clk);
    x = 1'b1;
    #1 check("R5 x high within period", z, exp_z);
    x = 1'b0;
    #1 check("R5 x low within period", z, exp_z);
    x = 1'b1;
    #1 check("R5 x high again within period", z, exp_z);
    exp_z = ~exp_z;
    exp_par = 1'b0;
    step(1'b0, "R5 toggled only after edge");
  endtask

  task automatic t_reference();
    bit [14:0] xs = 15'b001100010101110;
    bit [14:0] zs = 15'b000011111100011;
    do_reset();
    for (int i = 14; i >= 0; i--) begin
      @(negedge clk);
      x = xs[i];
      #1 check("R6 reference stream", z, zs[i]);
    end
  endtask

  task automatic t_reset_midrun();
    do_reset();
    step(1'b1, "R7 setup pair");
    step(1'b1, "R7 setup pair");
    step(1'b1, "R7 pending odd 1");
    do_reset();
    step(1'b1, "R7 cleared output");
    step(1'b0, "R7 first 1 no toggle");
    step(1'b1, "R7 second 1");
    step(1'b0, "R7 toggles after second 1");
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    t_reset();
    t_odd_ones();
    t_even_toggle();
    t_zeros_hold();
    t_moore();
    t_reference();
    t_reset_midrun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule